// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block guards a system against hung software with two escalation levels. They are measured against absolute deadlines on a shared free-running time base. The block has its own time counter, which advances by one on every clock. With a 100 MHz clock each step is 10 ns.

Software keeps the system alive by moving a first deadline further into the future again and again. If the time passes that deadline, the block interrupts a processor core and arms a second deadline. If the time also passes the second deadline while it is armed, the block raises a request to an external management unit that resets the system. Software can recover before the second stage fires by writing a new first deadline. That single write clears the core interrupt and disarms the second stage. Both deadlines are written through a simple one-cycle write strobe with a register select.

Top module: `dual_stage_watchdog`

## Requirements
- R1: `time_now` is 0 in the cycle after reset and increases by exactly one on every clock edge while out of reset.
- R2: During reset and after it, `irq_core` and `rst_req` are low, and both deadlines hold all ones, so neither output rises while no deadline has been written.
- R3: A write (`wr_en` high) with `wr_sel` = 0 loads the first deadline, and with `wr_sel` = 1 loads the second deadline. All 64 bits are loaded at once at that clock edge, and the comparison at the next edge uses the new value.
- R4: `irq_core` rises one edge after an edge where `time_now` is strictly greater than the first deadline. Equality does not trigger. `irq_core` then stays high until the first deadline is written again.
- R5: A write to the first deadline drives `irq_core` low from that edge on and disarms the second stage. If the written value is already in the past, `irq_core` rises again one edge later.
- R6: `rst_req` rises one edge after an edge where `irq_core` is high, `time_now` is strictly greater than the second deadline, and no write to the first deadline occurs. A first-deadline write at that edge wins and suppresses the request.
- R7: A second deadline that lies in the past while `irq_core` is low raises no `rst_req`.
- R8: Once `rst_req` is high it stays high until reset, whatever is written to either deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one time step per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Deadline write strobe |
| wr_sel | input | 1 | 0 selects the first deadline, 1 selects the second |
| wr_data | input | TW (64) | Deadline value to load |
| time_now | output | TW (64) | Current platform time |
| irq_core | output | 1 | Stage-1 interrupt toward a processor core |
| rst_req | output | 1 | Stage-2 reset request toward the management unit |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that the time counter never wraps, which a 64-bit counter cannot do in any real run. The stimulus drives every input on the falling edge. It uses deadlines placed a few steps around the current time, so every compare outcome is reached: past, equal and future. Each run stays tens of thousands of steps away from the counter's range limit.

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [TW-1:0] wr_data,
  output logic [TW-1:0] time_now,
  output logic          irq_core,
  output logic          rst_req
);

  logic [TW-1:0] dl1, dl2;
  logic          wr1, wr2, late1, late2;

  assign wr1   = wr_en & ~wr_sel;
  assign wr2   = wr_en & wr_sel;
  assign late1 = time_now > dl1;
  assign late2 = time_now > dl2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_now <= '0;
      dl1      <= '1;
      dl2      <= '1;
      irq_core <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      time_now <= time_now + TW'(1);
      if (wr1) dl1 <= wr_data;
      if (wr2) dl2 <= wr_data;
      irq_core <= wr1 ? 1'b0 : (irq_core | late1);
      rst_req  <= rst_req | (irq_core & late2 & ~wr1);
    end
  end

endmodule

module dual_stage_watchdog_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [TW-1:0] time_now,
  input logic          irq_core,
  input logic          rst_req,
  input logic [TW-1:0] dl1,
  input logic [TW-1:0] dl2
);

  a_r1_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_now == $past(time_now) + TW'(1));

  a_r4_rise_after_late: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_core) |-> $past(time_now > dl1));

  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> !irq_core);

  a_r6_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(irq_core) && $past(time_now > dl2)));

  a_r8_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

endmodule

bind dual_stage_watchdog dual_stage_watchdog_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .time_now(time_now), .irq_core(irq_core), .rst_req(rst_req),
  .dl1(dl1), .dl2(dl2)
);

// File: tb/sim_dual_stage_watchdog.sv
module sim_dual_stage_watchdog;
  localparam int TW = 64;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [TW-1:0] wr_data = '0;
  logic [TW-1:0] time_now;
  logic          irq_core, rst_req;

  int checks = 0, fails = 0;
  string phase = "R2";
  logic [TW-1:0] m_t, m_d1, m_d2, t0;
  logic m_i1, m_i2;

  dual_stage_watchdog #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .time_now(time_now), .irq_core(irq_core), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic nx_irq(logic cur, logic w1, logic [TW-1:0] t, logic [TW-1:0] d1);
    if (w1) return 1'b0;
    return cur | (t > d1);
  endfunction

  function automatic logic nx_req(logic cur, logic armed, logic w1, logic [TW-1:0] t, logic [TW-1:0] d2);
    return cur | (armed & !w1 & (t > d2));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t <= '0; m_d1 <= '1; m_d2 <= '1; m_i1 <= 1'b0; m_i2 <= 1'b0;
    end else begin
      m_t <= m_t + TW'(1);
      if (wr_en && !wr_sel) m_d1 <= wr_data;
      if (wr_en && wr_sel)  m_d2 <= wr_data;
      m_i1 <= nx_irq(m_i1, wr_en && !wr_sel, m_t, m_d1);
      m_i2 <= nx_req(m_i2, m_i1, wr_en && !wr_sel, m_t, m_d2);
    end
  end

  task automatic chk(input logic ok, input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(time_now == m_t, "R1", time_now, m_t);
    chk(irq_core == m_i1, phase, TW'(irq_core), TW'(m_i1));
    chk(rst_req == m_i2, phase, TW'(rst_req), TW'(m_i2));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic wr(input logic sel, input logic [TW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(time_now == '0, "R2", time_now, '0);
    chk(!irq_core && !rst_req, "R2", TW'({irq_core, rst_req}), '0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    do_reset();
    phase = "R2";
    repeat (20) tick();
    chk(time_now == 64'd20, "R1", time_now, 64'd20);
    chk(!irq_core, "R2", TW'(irq_core), '0);

    phase = "R4";
    t0 = time_now + 64'd4;
    wr(1'b0, t0);
    while (time_now != t0 + 64'd1) tick();
    chk(!irq_core, "R4 equal", TW'(irq_core), '0);
    tick();
    chk(irq_core, "R4 past", TW'(irq_core), 64'd1);
    repeat (5) tick();
    chk(irq_core, "R4 held", TW'(irq_core), 64'd1);

    phase = "R5";
    wr(1'b0, time_now + 64'd100);
    chk(!irq_core, "R5 clear", TW'(irq_core), '0);
    wr(1'b0, time_now - 64'd3);
    chk(!irq_core, "R5 clear", TW'(irq_core), '0);
    tick();
    chk(irq_core, "R5 retrigger", TW'(irq_core), 64'd1);

    phase = "R7";
    wr(1'b0, time_now + 64'd1000);
    wr(1'b1, time_now - 64'd1);
    repeat (10) tick();
    chk(!rst_req, "R7", TW'(rst_req), '0);

    phase = "R6";
    wr(1'b0, time_now);
    tick();
    chk(irq_core && !rst_req, "R6 arm", TW'({irq_core, rst_req}), 64'd2);
    wr(1'b0, time_now + 64'd1000);
    chk(!rst_req, "R6 priority", TW'(rst_req), '0);
    wr(1'b0, time_now);
    tick();
    chk(irq_core, "R6 arm", TW'(irq_core), 64'd1);
    tick();
    chk(rst_req, "R6 fire", TW'(rst_req), 64'd1);

    phase = "R8";
    wr(1'b0, time_now + 64'd1000);
    wr(1'b1, '1);
    repeat (5) tick();
    chk(rst_req && !irq_core, "R8 sticky", TW'({irq_core, rst_req}), 64'd1);

    @(negedge clk);
    do_reset();
    phase = "R3";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(9) < 3) begin
        wr_en = 1'b1;
        wr_sel = 1'($urandom_range(1));
        wr_data = time_now + 64'($urandom_range(32)) - 64'd8;
      end else begin
        wr_en = 1'b0;
      end
      tick();
      if (i % 500 == 499) begin
        wr_en = 1'b0;
        @(negedge clk);
        do_reset();
      end
    end
    wr_en = 1'b0;
    finish_run();
  end
endmodule